// File: doc/BRIEF.md
# Serial Output-Command and Diagnostic Port

This block is the slave side of a serial link that sets eight on/off channel commands and, in the same transfer, hands eight per-channel diagnostic bits back to the host. The host pulls an active-low select line, clocks bits in on a serial data input and reads bits back on a serial data output. Selection has two edges that each do a job. When select goes low, the block takes a snapshot of the diagnostic vector from the protection logic. When select goes high again, all eight commands take effect together, but only if the transfer was well formed.

Every serial input is oversampled by a fast system clock through two-flop synchronizers, and edges are found in that clock domain. The serial data output comes with an enable for a three-state pad. The block also drives a single-cycle valid-frame pulse that the fault logic uses to clear latched conditions. A frame is valid only if the count of serial clock rising edges seen while selected is a non-zero multiple of eight. In a longer valid frame only the last eight bits count, so a host that can only send 16-bit words puts a dummy byte first.

Top module: `drv_serial_port`

## Requirements
- R1: After reset the command register is all zeros (all channels off), the valid-frame pulse is low and the output enable is low.
- R2: The serial output enable is high only while the synchronized select is low. Otherwise the output is high impedance.
- R3: A falling select edge captures the diagnostic vector, and channel 1 (bit 0) is presented on the serial output before the first serial clock.
- R4: Each rising serial clock edge while selected moves the serial output to the next channel, in order 1 to 8 (bit 0 to bit 7). After channel 8 the sequence repeats from channel 1.
- R5: Input data is sampled on the rising serial clock edge. The first bit of the final eight lands in command bit 0 (channel 1) and the last lands in bit 7 (channel 8).
- R6: On a rising select edge that ends a valid frame, all eight command bits are replaced in the same system clock cycle.
- R7: A 16-clock frame is valid, and only its last eight bits become the command. The same holds for any longer multiple of eight.
- R8: A frame with zero clocks, or with a count that is not a multiple of eight, leaves the command register unchanged.
- R9: A valid frame produces exactly one system-clock-wide valid-frame pulse, one cycle after the rising select edge is detected. An invalid frame produces none.
- R10: Serial clock edges while deselected neither shift data nor count toward the next frame.
- R11: Changes of the diagnostic vector after the select falling edge do not alter the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low select from the host |
| sclk_i | input | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Serial data from the host |
| diag_i | input | 8 | Per-channel diagnostic vector, bit 0 is channel 1 |
| sdo_o | output | 1 | Serial diagnostic data to the host |
| sdo_oe_o | output | 1 | Enable for the three-state serial output pad |
| cmd_o | output | 8 | Committed channel commands, bit 0 is channel 1 |
| frame_ok_o | output | 1 | One-cycle pulse when a valid frame is committed |

## Verification
Frames of 8, 16 and 24 clocks with distinct data patterns show that only the trailing byte commits and that bit order is preserved. Counts of 0, 5 and 12 show that invalid frames leave the commands and the pulse untouched. A run of serial clock edges while deselected, followed by a clean 8-bit frame, shows that such edges are not counted. A diagnostic change made mid-frame shows that the snapshot is held. A behavioural reference model compares every output on every system clock cycle.

// File: rtl/drv_serial_pkg.sv
package drv_serial_pkg;

  localparam int unsigned CH_COUNT_DEF = 8;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  typedef struct packed {
    logic sel_act;
    logic sel_fall;
    logic sel_rise;
    logic sclk_rise;
  } dsp_evt_t;

endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned BITS = 3,
  parameter logic [BITS-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] d_i,
  output logic [BITS-1:0] q_o
);

  logic [STAGES-1:0][BITS-1:0] pipe_q;
  logic [STAGES-1:0][BITS-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_comb begin
        pipe_d[s] = pipe_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/dsp_edges.sv
module dsp_edges
  import drv_serial_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_s_i,
  input  logic     sclk_s_i,
  output dsp_evt_t evt_o
);

  logic sel_prev_q, sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q  <= 1'b1;
      sclk_prev_q <= 1'b1;
    end else begin
      sel_prev_q  <= sel_s_i;
      sclk_prev_q <= sclk_s_i;
    end
  end

  always_comb begin
    evt_o.sel_act   = ~sel_s_i;
    evt_o.sel_fall  = sel_prev_q & ~sel_s_i;
    evt_o.sel_rise  = ~sel_prev_q & sel_s_i;
    evt_o.sclk_rise = ~sclk_prev_q & sclk_s_i & ~sel_s_i;
  end

endmodule

// File: rtl/dsp_shift.sv
module dsp_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         sdi_s_i,
  input  logic [W-1:0] diag_i,
  output logic         sdo_o,
  output logic [W-1:0] rx_o
);

  logic [W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic         tx_en, rx_en;

  always_comb begin
    tx_en = load_i | step_i;
    tx_d  = tx_q;
    if (load_i)      tx_d = diag_i;
    else if (step_i) tx_d = {tx_q[0], tx_q[W-1:1]};
    rx_en = step_i;
    rx_d  = {sdi_s_i, rx_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (tx_en) tx_q <= tx_d;
      if (rx_en) rx_q <= rx_d;
    end
  end

  assign sdo_o = tx_q[0];
  assign rx_o  = rx_q;

endmodule

// File: rtl/dsp_frame.sv
module dsp_frame #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         end_i,
  input  logic         tick_i,
  input  logic [W-1:0] rx_i,
  output logic [W-1:0] cmd_o,
  output logic         ok_o
);

  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;
  logic [W-1:0]  cmd_q;
  logic          ok_q, commit;

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    if (start_i) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (tick_i) begin
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      seen_d = 1'b1;
    end
    commit = end_i & seen_q & (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      cmd_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      if (start_i | tick_i) begin
        cnt_q  <= cnt_d;
        seen_q <= seen_d;
      end
      if (commit) cmd_q <= rx_i;
      ok_q <= commit;
    end
  end

  assign cmd_o = cmd_q;
  assign ok_o  = ok_q;

  // R9: the pulse never lasts two cycles
  p_ok_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |=> !ok_q);

endmodule

// File: rtl/drv_serial_port.sv
module drv_serial_port
  import drv_serial_pkg::*;
#(
  parameter int unsigned CH_COUNT   = CH_COUNT_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n_i,
  input  logic                sclk_i,
  input  logic                sdi_i,
  input  logic [CH_COUNT-1:0] diag_i,
  output logic                sdo_o,
  output logic                sdo_oe_o,
  output logic [CH_COUNT-1:0] cmd_o,
  output logic                frame_ok_o
);

  logic [2:0]          raw_in, syn_out;
  dsp_evt_t            evt;
  logic [CH_COUNT-1:0] rx_word;

  assign raw_in = {sdi_i, sclk_i, sel_n_i};

  dsp_sync #(
    .STAGES (SYNC_DEPTH),
    .BITS   (3),
    .RST_VAL(3'b011)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_in),
    .q_o  (syn_out)
  );

  dsp_edges u_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_s_i (syn_out[0]),
    .sclk_s_i(syn_out[1]),
    .evt_o   (evt)
  );

  dsp_shift #(.W(CH_COUNT)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (evt.sel_fall),
    .step_i (evt.sclk_rise),
    .sdi_s_i(syn_out[2]),
    .diag_i (diag_i),
    .sdo_o  (sdo_o),
    .rx_o   (rx_word)
  );

  dsp_frame #(.W(CH_COUNT)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(evt.sel_fall),
    .end_i  (evt.sel_rise),
    .tick_i (evt.sclk_rise),
    .rx_i   (rx_word),
    .cmd_o  (cmd_o),
    .ok_o   (frame_ok_o)
  );

  assign sdo_oe_o = evt.sel_act;

  // R8: commands move only together with a valid-frame pulse
  p_cmd_only_on_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_o) |-> frame_ok_o);

  // R9: a pulse is always preceded by a detected select rise
  p_ok_after_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok_o |-> $past(evt.sel_rise));

  // R4: the serial output holds unless a clock rise or select fall occurred
  p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.sclk_rise && !evt.sel_fall) |=> $stable(sdo_o));

  // R10: received bits stay put while deselected
  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.sel_act |=> $stable(rx_word));

endmodule

// File: tb/drv_serial_port_bench.sv
module drv_serial_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1;
  logic       sclk = 1'b1;
  logic       sdi = 1'b0;
  logic [7:0] diag = 8'h00;
  logic       sdo, sdo_oe, frame_ok;
  logic [7:0] cmd;

  int vectors = 0;
  int errors = 0;
  int ok_seen = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  drv_serial_port u_drv_serial_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n_i   (sel_n),
    .sclk_i    (sclk),
    .sdi_i     (sdi),
    .diag_i    (diag),
    .sdo_o     (sdo),
    .sdo_oe_o  (sdo_oe),
    .cmd_o     (cmd),
    .frame_ok_o(frame_ok)
  );

  // behavioural reference model
  logic h_sel[3], h_sck[3], h_d[3];
  bit   rxq[$];
  int   m_cnt;
  logic [7:0] m_snap, m_cmd;
  int   m_ptr;
  logic m_ok, m_oe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        h_sel[i] = 1'b1; h_sck[i] = 1'b1; h_d[i] = 1'b0;
      end
      rxq.delete();
      m_cnt = 0; m_snap = 8'h00; m_ptr = 0; m_cmd = 8'h00;
      m_ok = 1'b0; m_oe = 1'b0;
    end else begin
      logic fall, rise, srise;
      fall  = h_sel[2] && !h_sel[1];
      rise  = !h_sel[2] && h_sel[1];
      srise = !h_sck[2] && h_sck[1] && !h_sel[1];
      m_ok = 1'b0;
      if (rise && m_cnt > 0 && (m_cnt % 8) == 0) begin
        for (int i = 0; i < 8; i++) m_cmd[i] = rxq[rxq.size() - 8 + i];
        m_ok = 1'b1;
      end
      if (srise) rxq.push_back(h_d[1]);
      if (fall) begin
        m_snap = diag; m_ptr = 0; m_cnt = 0; rxq.delete();
      end else if (srise) begin
        m_ptr = (m_ptr + 1) % 8; m_cnt++;
      end
      h_sel[2] = h_sel[1]; h_sel[1] = h_sel[0]; h_sel[0] = sel_n;
      h_sck[2] = h_sck[1]; h_sck[1] = h_sck[0]; h_sck[0] = sclk;
      h_d[2]   = h_d[1];   h_d[1]   = h_d[0];   h_d[0]   = sdi;
      m_oe = !h_sel[1];
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (frame_ok) ok_seen++;
    if (rst_n && !done) begin
      vectors++;
      if (sdo_oe !== m_oe) begin
        errors++; $display("FAIL R2 cycle %0d: sdo_oe=%b expected %b", cycles, sdo_oe, m_oe);
      end
      if (cmd !== m_cmd) begin
        errors++; $display("FAIL R6 cycle %0d: cmd=%h expected %h", cycles, cmd, m_cmd);
      end
      if (frame_ok !== m_ok) begin
        errors++; $display("FAIL R9 cycle %0d: frame_ok=%b expected %b", cycles, frame_ok, m_ok);
      end
      if (m_oe && sdo !== m_snap[m_ptr]) begin
        errors++; $display("FAIL R4 cycle %0d: sdo=%b expected %b", cycles, sdo, m_snap[m_ptr]);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // send n bits, bit i from bits[i]; diagnostics dg; optionally flip diag mid-frame
  task automatic xfer(input int n, input logic [31:0] bits, input logic [7:0] dg,
                      input bit flip, input logic [7:0] prev_cmd);
    logic [7:0] exp_cmd;
    int ok0;
    diag = dg;
    @(negedge clk);
    ok0 = ok_seen;
    sel_n = 1'b0;
    wait_cyc(5);
    check("R2 enable while selected", {31'd0, sdo_oe}, 32'd1);
    if (n > 0) check("R3 first bit is channel 1", {31'd0, sdo}, {31'd0, dg[0]});
    if (flip) diag = ~dg;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; sdi = bits[i];
      wait_cyc(4);
      if (flip) check("R11 snapshot held", {31'd0, sdo}, {31'd0, dg[i % 8]});
      else      check("R4 channel order", {31'd0, sdo}, {31'd0, dg[i % 8]});
      sclk = 1'b1;
      wait_cyc(4);
    end
    sel_n = 1'b1;
    wait_cyc(6);
    check("R2 high impedance when deselected", {31'd0, sdo_oe}, 32'd0);
    if (n > 0 && (n % 8) == 0) begin
      exp_cmd = bits[n-8 +: 8];
      check(n > 8 ? "R7 trailing byte commits" : "R5 R6 byte commits", {24'd0, cmd}, {24'd0, exp_cmd});
      check("R9 one pulse", ok_seen - ok0, 32'd1);
    end else begin
      check("R8 invalid frame keeps command", {24'd0, cmd}, {24'd0, prev_cmd});
      check("R9 no pulse on invalid frame", ok_seen - ok0, 32'd0);
    end
  endtask

  initial begin
    wait_cyc(4);
    check("R1 reset cmd", {24'd0, cmd}, 32'd0);
    check("R1 reset pulse", {31'd0, frame_ok}, 32'd0);
    check("R1 reset enable", {31'd0, sdo_oe}, 32'd0);
    rst_n = 1'b1;
    wait_cyc(4);
    xfer(8,  32'h0000_00A5, 8'h3C, 0, 8'h00);
    xfer(8,  32'h0000_000F, 8'h81, 0, 8'hA5);
    xfer(16, 32'h0000_5AFF, 8'hE7, 0, 8'h0F);
    xfer(5,  32'h0000_001F, 8'h12, 0, 8'h5A);
    xfer(0,  32'h0,         8'h34, 0, 8'h5A);
    xfer(12, 32'h0000_0FFF, 8'h56, 0, 8'h5A);
    // R10: clock edges while deselected are ignored
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; sdi = 1'b1; wait_cyc(4);
      sclk = 1'b1; wait_cyc(4);
    end
    check("R10 idle clocks keep command", {24'd0, cmd}, 32'h5A);
    xfer(8,  32'h0000_0096, 8'hC9, 0, 8'h5A);
    xfer(8,  32'h0000_0069, 8'h4B, 1, 8'h96);
    xfer(24, 32'h00C3_1122, 8'hD2, 0, 8'h69);
    wait_cyc(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait_cyc(150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule